// File: doc/BRIEF.md
# Configurable UART Frame Receiver

This block takes an asynchronous serial line, finds the start of each frame, and assembles a character of 5 to 9 data bits with an optional parity bit. The line is brought into the clock domain through a short synchronizer. It is then sampled sixteen times per bit, with the sampling pace set by a 12-bit divisor. Each finished character goes into a one-deep holding buffer. The buffer keeps the low 8 data bits and a separate ninth bit, and raises a completion flag. Framing, overrun and parity error flags stay with the buffered character. An interrupt request is raised when the completion flag is set and both interrupt enables allow it.

The block has a multi-processor filter mode. In this mode, frames whose final data bit is 0 are data frames and are thrown away without trace: no data is stored and no flag moves. Frames whose final data bit is 1 are address frames and are accepted as usual. Clearing the enable input empties the buffer and wipes every flag. A single-cycle read strobe marks the buffered character as consumed.

Top module: `uart_frame_rx`

## Requirements
- R1: The size code selects the data bit count: 000→5, 001→6, 010→7, 011→8, 111→9. The reserved codes 100, 101 and 110 act as 8. Data arrives LSB first. It is right-aligned in `rx_data`, and unused upper bits read 0.
- R2: In 9-bit mode the ninth data bit (the last one received) appears on `rx_bit9`. In every other size `rx_bit9` reads 0.
- R3: Parity mode 10 means even parity and 11 means odd parity. In both, one parity bit follows the data, and `parity_err` is set when the data bits and the parity bit do not give the selected parity. Modes 00 and 01 expect no parity bit, and `parity_err` stays 0.
- R4: `frame_err` is set when the majority-voted sample of the first stop bit is 0. Only one stop bit is checked, so a new start bit may follow the first stop bit directly.
- R5: If a frame completes while `rx_done` is still 1 and no read strobe arrives in that cycle, `overrun` is set and the buffered data is left unchanged.
- R6: A falling edge counts as a start bit only if the majority of the three centre samples of that bit is low. A shorter low pulse produces no frame.
- R7: Each bit value is the majority of the samples at oversample positions 7, 8 and 9 of the 16, so a one-sample glitch in a bit does not change the result.
- R8: With `mp_mode` set, a frame whose final data bit is 0 leaves `rx_done`, `rx_data` and all flags unchanged. A frame whose final data bit is 1 is accepted normally.
- R9: While `rx_en` is 0, the buffer is cleared (`rx_data` 0, `rx_bit9` 0) and `rx_done`, `frame_err`, `overrun` and `parity_err` are all 0.
- R10: `irq` is 1 exactly when `rx_done`, `rx_ie` and `global_ie` are all 1.
- R11: A one-cycle `rd_strobe` clears `rx_done` and all error flags. Each accepted frame sets `rx_done` once.
- R12: One oversample tick is produced every `baud_div`+1 clock cycles, so one bit lasts 16×(`baud_div`+1) clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receiver enable; low flushes buffer and flags |
| rxd | input | 1 | Serial input line, idle high |
| baud_div | input | 12 | Oversample tick divisor minus one |
| size_code | input | 3 | Data bit count code |
| par_mode | input | 2 | Parity mode code |
| mp_mode | input | 1 | Multi-processor address filter enable |
| rx_ie | input | 1 | Local receive interrupt enable |
| global_ie | input | 1 | Global interrupt enable |
| rd_strobe | input | 1 | One-cycle pulse marking the buffered character consumed |
| rx_data | output | 8 | Low 8 data bits of buffered character |
| rx_bit9 | output | 1 | Ninth data bit in 9-bit mode |
| rx_done | output | 1 | Buffer holds an unread character |
| frame_err | output | 1 | Stop bit of buffered character was 0 |
| overrun | output | 1 | A frame was lost because the buffer was full |
| parity_err | output | 1 | Parity mismatch on buffered character |
| irq | output | 1 | Receive-complete interrupt request |

## Verification
The bench uses the default parameters: 16 samples per bit, a 12-bit divisor and a two-stage synchronizer. Most frames run with a divisor of 0, which makes one bit 16 clocks long. That short bit time lets the bench cover every size code against every parity choice and several bit patterns, and a single-clock line glitch lands on exactly one oversample. One frame uses a divisor of 2 to show that the tick period follows the divisor.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP
   } rx_state_t;

   typedef struct packed {
      logic [8:0] data;
      logic       addr;
      logic       ferr;
      logic       perr;
   } rx_frame_t;

   function automatic logic [3:0] size_bits(input logic [2:0] code);
      case (code)
         3'b000:  size_bits = 4'd5;
         3'b001:  size_bits = 4'd6;
         3'b010:  size_bits = 4'd7;
         3'b111:  size_bits = 4'd9;
         default: size_bits = 4'd8;
      endcase
   endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   logic [STAGES-1:0] q;

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("uart_rx_sync: STAGES must be at least 1");
      end
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '1;
            else        q <= din;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '1;
            else        q <= {q[STAGES-2:0], din};
         end
      end
   endgenerate

   assign dout = q[STAGES-1];
endmodule

// File: rtl/uart_rx_baud.sv
module uart_rx_baud #(
   parameter int DIV_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         tick <= 1'b0;
      end else if (!en) begin
         cnt  <= '0;
         tick <= 1'b0;
      end else if (cnt >= div) begin
         cnt  <= '0;
         tick <= 1'b1;
      end else begin
         cnt  <= cnt + 1'b1;
         tick <= 1'b0;
      end
   end

   // R12
   tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && div != '0) |=> !tick);
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame import uart_rx_pkg::*; #(
   parameter int OSR = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic       tick,
   input  logic       rxd,
   input  logic [2:0] size_code,
   input  logic [1:0] par_mode,
   output logic       frm_valid,
   output rx_frame_t  frm
);
   localparam int CNT_W = $clog2(OSR);
   localparam int MID   = OSR / 2;
   localparam logic [CNT_W-1:0] P_A   = CNT_W'(MID - 1);
   localparam logic [CNT_W-1:0] P_B   = CNT_W'(MID);
   localparam logic [CNT_W-1:0] P_C   = CNT_W'(MID + 1);
   localparam logic [CNT_W-1:0] P_END = CNT_W'(OSR - 1);

   rx_state_t        state;
   logic [CNT_W-1:0] cnt;
   logic             prev, s_a, s_b, vote, pbit;
   logic [8:0]       sh;
   logic [3:0]       nleft;
   logic [3:0]       nb;
   logic [8:0]       aligned;
   logic             maj, par_on, perr_now;

   always_comb begin
      nb       = size_bits(size_code);
      aligned  = sh >> (4'd9 - nb);
      maj      = (s_a & s_b) | (s_a & rxd) | (s_b & rxd);
      par_on   = par_mode[1];
      perr_now = par_on & ((^aligned) ^ pbit ^ par_mode[0]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         cnt       <= '0;
         prev      <= 1'b1;
         s_a       <= 1'b1;
         s_b       <= 1'b1;
         vote      <= 1'b1;
         pbit      <= 1'b0;
         sh        <= '0;
         nleft     <= '0;
         frm_valid <= 1'b0;
         frm       <= '0;
      end else begin
         frm_valid <= 1'b0;
         if (!en) begin
            state <= ST_IDLE;
            cnt   <= '0;
            prev  <= 1'b1;
         end else if (tick) begin
            prev <= rxd;
            if (state == ST_IDLE) begin
               if (prev && !rxd) begin
                  state <= ST_START;
                  cnt   <= CNT_W'(1);
               end
            end else begin
               cnt <= cnt + 1'b1;
               if (cnt == P_A) s_a <= rxd;
               if (cnt == P_B) s_b <= rxd;
               if (cnt == P_C) begin
                  vote <= maj;
                  if (state == ST_STOP) begin
                     state     <= ST_IDLE;
                     frm_valid <= 1'b1;
                     frm.data  <= aligned;
                     frm.addr  <= sh[8];
                     frm.ferr  <= !maj;
                     frm.perr  <= perr_now;
                  end
               end
               if (cnt == P_END) begin
                  case (state)
                     ST_START: begin
                        if (vote) begin
                           state <= ST_IDLE;
                        end else begin
                           state <= ST_DATA;
                           nleft <= nb;
                           sh    <= '0;
                        end
                     end
                     ST_DATA: begin
                        sh    <= {vote, sh[8:1]};
                        nleft <= nleft - 4'd1;
                        if (nleft == 4'd1) state <= par_on ? ST_PAR : ST_STOP;
                     end
                     ST_PAR: begin
                        pbit  <= vote;
                        state <= ST_STOP;
                     end
                     default: ;
                  endcase
               end
            end
         end
      end
   end

   // R11
   single_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frm_valid |=> !frm_valid);
endmodule

// File: rtl/uart_frame_rx.sv
module uart_frame_rx import uart_rx_pkg::*; #(
   parameter int DIV_W       = 12,
   parameter int OSR         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_en,
   input  logic             rxd,
   input  logic [DIV_W-1:0] baud_div,
   input  logic [2:0]       size_code,
   input  logic [1:0]       par_mode,
   input  logic             mp_mode,
   input  logic             rx_ie,
   input  logic             global_ie,
   input  logic             rd_strobe,
   output logic [7:0]       rx_data,
   output logic             rx_bit9,
   output logic             rx_done,
   output logic             frame_err,
   output logic             overrun,
   output logic             parity_err,
   output logic             irq
);
   generate
      if (OSR < 8 || (OSR & (OSR - 1)) != 0) begin : g_bad_osr
         $error("uart_frame_rx: OSR must be a power of two, at least 8");
      end
      if (DIV_W < 1 || DIV_W > 16) begin : g_bad_div
         $error("uart_frame_rx: DIV_W must be within 1..16");
      end
   endgenerate

   logic      rxd_s, tick, frm_valid, accept;
   rx_frame_t frm;

   uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(rxd), .dout(rxd_s)
   );

   uart_rx_baud #(.DIV_W(DIV_W)) u_baud (
      .clk(clk), .rst_n(rst_n), .en(rx_en), .div(baud_div), .tick(tick)
   );

   uart_rx_frame #(.OSR(OSR)) u_frame (
      .clk(clk), .rst_n(rst_n), .en(rx_en), .tick(tick), .rxd(rxd_s),
      .size_code(size_code), .par_mode(par_mode),
      .frm_valid(frm_valid), .frm(frm)
   );

   assign accept = frm_valid && !(mp_mode && !frm.addr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n || !rx_en) begin
         rx_data    <= '0;
         rx_bit9    <= 1'b0;
         rx_done    <= 1'b0;
         frame_err  <= 1'b0;
         overrun    <= 1'b0;
         parity_err <= 1'b0;
      end else begin
         if (rd_strobe) begin
            rx_done    <= 1'b0;
            frame_err  <= 1'b0;
            overrun    <= 1'b0;
            parity_err <= 1'b0;
         end
         if (accept) begin
            if (rx_done && !rd_strobe) begin
               overrun <= 1'b1;
            end else begin
               rx_data    <= frm.data[7:0];
               rx_bit9    <= frm.data[8];
               rx_done    <= 1'b1;
               frame_err  <= frm.ferr;
               parity_err <= frm.perr;
               overrun    <= 1'b0;
            end
         end
      end
   end

   assign irq = rx_done & rx_ie & global_ie;

   // R9
   flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |=> (!rx_done && !frame_err && !overrun && !parity_err && rx_data == 8'd0));
   // R5
   overrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overrun) |-> $past(rx_done));
   // R8
   mp_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_valid && rx_en && mp_mode && !frm.addr && !rd_strobe)
      |=> ($stable(rx_done) && $stable(rx_data)));
   // R11
   done_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_done) |-> $past(frm_valid));
endmodule

// File: tb/test_uart_frame_rx.sv
module test_uart_frame_rx;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_en = 1'b0;
   logic        rxd = 1'b1;
   logic [11:0] baud_div = 12'd0;
   logic [2:0]  size_code = 3'b011;
   logic [1:0]  par_mode = 2'b00;
   logic        mp_mode = 1'b0;
   logic        rx_ie = 1'b0;
   logic        global_ie = 1'b0;
   logic        rd_strobe = 1'b0;
   logic [7:0]  rx_data;
   logic        rx_bit9, rx_done, frame_err, overrun, parity_err, irq;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   uart_frame_rx i_uart_frame_rx (
      .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rxd(rxd), .baud_div(baud_div),
      .size_code(size_code), .par_mode(par_mode), .mp_mode(mp_mode),
      .rx_ie(rx_ie), .global_ie(global_ie), .rd_strobe(rd_strobe),
      .rx_data(rx_data), .rx_bit9(rx_bit9), .rx_done(rx_done),
      .frame_err(frame_err), .overrun(overrun), .parity_err(parity_err), .irq(irq)
   );

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic drive_bit(input logic v, input int bclk, input bit glitch);
      rxd = v;
      for (int c = 0; c < bclk; c++) begin
         if (glitch && c == 8) rxd = ~v;
         if (glitch && c == 9) rxd = v;
         @(negedge clk);
      end
   endtask

   task automatic send(input logic [8:0] d, input int nb, input bit par_en,
                       input bit odd, input bit bad_par, input logic stop_v,
                       input int bclk, input int glitch_bit);
      logic p;
      p = odd;
      drive_bit(1'b0, bclk, 1'b0);
      for (int i = 0; i < nb; i++) begin
         p ^= d[i];
         drive_bit(d[i], bclk, glitch_bit == i);
      end
      if (par_en) drive_bit(p ^ bad_par, bclk, 1'b0);
      drive_bit(stop_v, bclk, 1'b0);
      rxd = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   task automatic do_read;
      rd_strobe = 1'b1;
      @(negedge clk);
      rd_strobe = 1'b0;
      @(negedge clk);
   endtask

   function automatic logic [8:0] pat(input int k);
      case (k)
         0: pat = 9'h155;
         1: pat = 9'h0AA;
         2: pat = 9'h1FF;
         3: pat = 9'h000;
         default: pat = 9'h0C3;
      endcase
   endfunction

   initial begin
      repeat (400000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [8:0] d, m;
      repeat (4) @(negedge clk);
      // reset state
      check("R9 reset done", rx_done, 0);
      check("R9 reset flags", {frame_err, overrun, parity_err}, 0);
      check("R10 reset irq", irq, 0);
      rst_n = 1'b1;
      rx_en = 1'b1;
      repeat (20) @(negedge clk);

      // R1 R2 R3 sweep over sizes, parities, patterns
      for (int ci = 0; ci < 5; ci++) begin
         for (int pi = 0; pi < 3; pi++) begin
            for (int k = 0; k < 5; k++) begin
               int nb;
               nb = (ci == 4) ? 9 : 5 + ci;
               size_code = (ci == 4) ? 3'b111 : 3'(ci);
               par_mode  = (pi == 0) ? 2'b00 : 2'(pi + 1);
               d = pat(k);
               m = 9'((1 << nb) - 1);
               send(d, nb, pi != 0, pi == 2, 1'b0, 1'b1, 16, -1);
               check("R1 data", rx_data, int'(d & m & 9'h0FF));
               check("R2 ninth bit", rx_bit9, (nb == 9) ? int'(d[8]) : 0);
               check("R3 no parity error", parity_err, 0);
               check("R11 done set", rx_done, 1);
               do_read();
               check("R11 read clears", rx_done, 0);
            end
         end
      end

      // R1 reserved size code acts as 8 bits; R3 reserved parity acts as off
      size_code = 3'b101; par_mode = 2'b01;
      send(9'h15A, 8, 1'b0, 1'b0, 1'b0, 1'b1, 16, -1);
      check("R1 reserved size", rx_data, 'h5A);
      check("R3 reserved parity", parity_err, 0);
      do_read();

      // R3 bad parity, even and odd
      size_code = 3'b011; par_mode = 2'b10;
      send(9'h037, 8, 1'b1, 1'b0, 1'b1, 1'b1, 16, -1);
      check("R3 even mismatch", parity_err, 1);
      do_read();
      check("R11 read clears parity", parity_err, 0);
      par_mode = 2'b11;
      send(9'h037, 8, 1'b1, 1'b1, 1'b1, 1'b1, 16, -1);
      check("R3 odd mismatch", parity_err, 1);
      do_read();
      par_mode = 2'b00;

      // R4 stop bit low
      send(9'h0E1, 8, 1'b0, 1'b0, 1'b0, 1'b0, 16, -1);
      check("R4 frame error", frame_err, 1);
      check("R4 data kept", rx_data, 'hE1);
      repeat (20) @(negedge clk);
      do_read();
      send(9'h0E2, 8, 1'b0, 1'b0, 1'b0, 1'b1, 16, -1);
      check("R4 good stop", frame_err, 0);
      do_read();

      // R7 one-sample glitch in a data bit
      send(9'h0F0, 8, 1'b0, 1'b0, 1'b0, 1'b1, 16, 2);
      check("R7 glitch rejected", rx_data, 'hF0);
      do_read();

      // R6 short low pulse
      rxd = 1'b0;
      repeat (4) @(negedge clk);
      rxd = 1'b1;
      repeat (300) @(negedge clk);
      check("R6 false start", rx_done, 0);

      // R5 overrun
      send(9'h011, 8, 1'b0, 1'b0, 1'b0, 1'b1, 16, -1);
      send(9'h022, 8, 1'b0, 1'b0, 1'b0, 1'b1, 16, -1);
      check("R5 overrun flag", overrun, 1);
      check("R5 data kept", rx_data, 'h11);
      do_read();
      check("R11 read clears overrun", overrun, 0);

      // R4 R11 back-to-back frames with single stop bit
      fork
         begin
            send(9'h03C, 8, 1'b0, 1'b0, 1'b0, 1'b1, 16, -1);
            send(9'h0C5, 8, 1'b0, 1'b0, 1'b0, 1'b1, 16, -1);
         end
         begin
            @(posedge rx_done);
            @(negedge clk);
            check("R11 first of pair", rx_data, 'h3C);
            rd_strobe = 1'b1;
            @(negedge clk);
            rd_strobe = 1'b0;
         end
      join
      check("R4 second of pair", rx_data, 'hC5);
      check("R5 pair no overrun", overrun, 0);

      // R10 interrupt gating
      rx_ie = 1'b1; global_ie = 1'b0; @(negedge clk);
      check("R10 global off", irq, 0);
      global_ie = 1'b1; @(negedge clk);
      check("R10 all on", irq, 1);
      rx_ie = 1'b0; @(negedge clk);
      check("R10 local off", irq, 0);
      rx_ie = 1'b1;
      do_read();
      check("R10 done clear", irq, 0);
      rx_ie = 1'b0; global_ie = 1'b0;

      // R8 multi-processor filtering
      mp_mode = 1'b1;
      send(9'h041, 8, 1'b0, 1'b0, 1'b0, 1'b1, 16, -1);
      check("R8 data frame dropped", rx_done, 0);
      check("R8 dropped data", rx_data, 'hC5);
      send(9'h0C1, 8, 1'b0, 1'b0, 1'b0, 1'b1, 16, -1);
      check("R8 address accepted", rx_data, 'hC1);
      do_read();
      size_code = 3'b111;
      send(9'h0A5, 9, 1'b0, 1'b0, 1'b0, 1'b1, 16, -1);
      check("R8 9-bit dropped", rx_done, 0);
      send(9'h1A5, 9, 1'b0, 1'b0, 1'b0, 1'b1, 16, -1);
      check("R8 9-bit address", {rx_bit9, rx_data}, 'h1A5);
      do_read();
      mp_mode = 1'b0; size_code = 3'b011;

      // R9 flush
      par_mode = 2'b10;
      send(9'h055, 8, 1'b1, 1'b0, 1'b1, 1'b0, 16, -1);
      send(9'h066, 8, 1'b1, 1'b0, 1'b0, 1'b1, 16, -1);
      check("R9 flags before flush", {frame_err, overrun, parity_err}, 'b111);
      rx_en = 1'b0; @(negedge clk);
      rx_en = 1'b1; @(negedge clk);
      check("R9 flush flags", {rx_done, frame_err, overrun, parity_err}, 0);
      check("R9 flush data", rx_data, 0);
      par_mode = 2'b00;
      repeat (20) @(negedge clk);

      // R12 divider of 2: bit lasts 48 clocks
      baud_div = 12'd2;
      repeat (10) @(negedge clk);
      send(9'h096, 8, 1'b0, 1'b0, 1'b0, 1'b1, 48, -1);
      check("R12 slow frame", rx_data, 'h96);
      check("R12 slow done", rx_done, 1);
      do_read();

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule